// File: doc/BRIEF.md
# JTAG Identification Word Monitor

This block listens to a single-target JTAG link without driving any of its pins. It oversamples TCK, TMS and TDO with a fast system clock, rebuilds the test-access-port state from the TMS values seen on each rising TCK edge, and collects the bits the target presents on TDO during a data-register shift. When the controller reaches Update-DR after exactly 32 shifted bits, the monitor publishes the recovered identification word and pulses a valid strobe. Any other shift length raises a length-error flag instead.

Typical use is on a debug or board-management path, where logic needs to learn which part sits on the far end of a JTAG cable after the host has reset the chain and read its identification register. The monitor makes no decode of instruction values. It treats every complete 32-bit DR scan as a candidate word.

Top module: `jtag_idcode_monitor`

## Requirements
- R1: After rst_ni is released, state_o reads 0 (Test-Logic-Reset), id_o reads 0, and id_valid_o and len_err_o are low.
- R2: state_o advances by the standard 16-state TAP transition function, once for each rising TCK edge, using the TMS value sampled at that edge. It does not change while TCK does not rise. The encoding is Test-Logic-Reset=0, Run-Test/Idle=1, Select-DR=2, Capture-DR=3, Shift-DR=4, Exit1-DR=5, Pause-DR=6, Exit2-DR=7, Update-DR=8, Select-IR=9, Capture-IR=10, Shift-IR=11, Exit1-IR=12, Pause-IR=13, Exit2-IR=14, Update-IR=15.
- R3: Five consecutive rising TCK edges with TMS=1 bring state_o to Test-Logic-Reset from any state, and further TMS=1 edges keep it there.
- R4: TDO is sampled on each rising TCK edge taken while the state is Shift-DR. This includes the edge where TMS=1 leaves for Exit1-DR. The first bit lands in id_o bit 0 and later bits fill upward. For the reference capture, the result is 0x20614093.
- R5: On entry to Update-DR with exactly 32 collected bits, id_valid_o is high for one system clock while state_o is Update-DR. id_o then holds the word until the next good scan.
- R6: On entry to Update-DR with a bit count other than 32, len_err_o is set, id_valid_o stays low and id_o keeps its previous value.
- R7: len_err_o stays set until the next entry to Capture-DR, which clears it and restarts the bit count.
- R8: Visits to Pause-DR and Exit2-DR inside a scan add no bits and lose none. The word is assembled as if the shift had been continuous.
- R9: Instruction-register scans and resets out of Shift-DR never pulse id_valid_o and never change id_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than TCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tck_i | input | 1 | Observed JTAG test clock |
| tms_i | input | 1 | Observed JTAG mode select |
| tdo_i | input | 1 | Observed JTAG data from the target |
| state_o | output | 4 | Tracked TAP state, encoding per R2 |
| id_o | output | 32 | Last word recovered from a 32-bit DR scan |
| id_valid_o | output | 1 | One-cycle strobe when id_o is updated |
| len_err_o | output | 1 | DR scan ended with a length other than 32 |

## Verification
The bench replays a 52-edge recorded JTAG session and expects 0x20614093. A monitor that dropped the bit taken on the exit edge, or shifted in the wrong direction, would produce a different word or a length error. Scans of 31 and 33 bits check that an off-by-one counter is caught: a wrong design would either pulse valid or overwrite id_o. A scan broken by a Pause-DR excursion checks that no bit is counted on the Exit2-to-Shift edge. TMS and TDO are toggled with TCK held still, to confirm the state never moves without a rising clock edge. IR scans and a mid-shift reset are used to show that neither of them publishes a word.

// File: rtl/jtag_mon_pkg.sv
package jtag_mon_pkg;

  typedef enum logic [3:0] {
    TAP_RESET   = 4'd0,
    TAP_IDLE    = 4'd1,
    TAP_SEL_DR  = 4'd2,
    TAP_CAP_DR  = 4'd3,
    TAP_SH_DR   = 4'd4,
    TAP_EX1_DR  = 4'd5,
    TAP_PAU_DR  = 4'd6,
    TAP_EX2_DR  = 4'd7,
    TAP_UPD_DR  = 4'd8,
    TAP_SEL_IR  = 4'd9,
    TAP_CAP_IR  = 4'd10,
    TAP_SH_IR   = 4'd11,
    TAP_EX1_IR  = 4'd12,
    TAP_PAU_IR  = 4'd13,
    TAP_EX2_IR  = 4'd14,
    TAP_UPD_IR  = 4'd15
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    unique case (s)
      TAP_RESET:  n = m ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   n = m ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: n = m ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: n = m ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  n = m ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: n = m ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: n = m ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: n = m ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: n = m ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: n = m ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: n = m ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  n = m ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: n = m ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: n = m ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: n = m ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: n = m ? TAP_SEL_DR : TAP_IDLE;
      default:    n = TAP_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jtag_mon_sync.sv
module jtag_mon_sync #(
  parameter int unsigned          STAGES    = 2,
  parameter int unsigned          LANES     = 3,
  parameter logic [LANES-1:0]     RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] sync_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= {STAGES{RESET_VAL[l]}};
      else         q <= {q[STAGES-2:0], async_i[l]};
    end
    assign sync_o[l] = q[STAGES-1];
  end

endmodule

// File: rtl/jtag_mon_tap.sv
module jtag_mon_tap
  import jtag_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= TAP_RESET;
    else if (step_i) state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;

endmodule

// File: rtl/jtag_mon_capture.sv
module jtag_mon_capture
  import jtag_mon_pkg::*;
#(
  parameter int unsigned ID_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            tms_i,
  input  logic            tdo_i,
  input  tap_state_e      state_i,
  output logic [ID_W-1:0] id_o,
  output logic            valid_o,
  output logic            len_err_o
);

  localparam int unsigned CNT_W = $clog2(ID_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(ID_W);

  logic [ID_W-1:0]  shift_q, id_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q, err_q;
  logic             enter_cap, enter_upd, do_shift;

  assign enter_cap = step_i && !tms_i && (state_i == TAP_SEL_DR);
  assign enter_upd = step_i &&  tms_i &&
                     ((state_i == TAP_EX1_DR) || (state_i == TAP_EX2_DR));
  // the exit edge out of Shift-DR still carries a data bit
  assign do_shift  = step_i && (state_i == TAP_SH_DR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      id_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (enter_cap) begin
        cnt_q <= '0;
        err_q <= 1'b0;
      end
      if (do_shift) begin
        shift_q <= {tdo_i, shift_q[ID_W-1:1]};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (enter_upd) begin
        if (cnt_q == CNT_GOOD) begin
          id_q    <= shift_q;
          valid_q <= 1'b1;
        end else begin
          err_q   <= 1'b1;
        end
      end
    end
  end

  assign id_o      = id_q;
  assign valid_o   = valid_q;
  assign len_err_o = err_q;

endmodule

// File: rtl/jtag_idcode_monitor.sv
module jtag_idcode_monitor
  import jtag_mon_pkg::*;
#(
  parameter int unsigned ID_W        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tck_i,
  input  logic            tms_i,
  input  logic            tdo_i,
  output logic [3:0]      state_o,
  output logic [ID_W-1:0] id_o,
  output logic            id_valid_o,
  output logic            len_err_o
);

  // lane order: {tdo, tms, tck}; idle-high pull-ups on tms and tdo
  logic [2:0] pins_s;
  logic       tck_s, tms_s, tdo_s, tck_q, tck_rise;
  tap_state_e state;

  jtag_mon_sync #(
    .STAGES    (SYNC_STAGES),
    .LANES     (3),
    .RESET_VAL (3'b110)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({tdo_i, tms_i, tck_i}),
    .sync_o  (pins_s)
  );

  assign tck_s = pins_s[0];
  assign tms_s = pins_s[1];
  assign tdo_s = pins_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tck_q <= 1'b0;
    else         tck_q <= tck_s;
  end

  assign tck_rise = tck_s && !tck_q;

  jtag_mon_tap u_tap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tck_rise),
    .tms_i   (tms_s),
    .state_o (state)
  );

  jtag_mon_capture #(.ID_W(ID_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (tck_rise),
    .tms_i     (tms_s),
    .tdo_i     (tdo_s),
    .state_i   (state),
    .id_o      (id_o),
    .valid_o   (id_valid_o),
    .len_err_o (len_err_o)
  );

  assign state_o = state;

endmodule

// File: rtl/jtag_idcode_monitor_chk.sv
module jtag_idcode_monitor_chk #(
  parameter int unsigned ID_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tck_rise,
  input logic            tms_s,
  input logic [3:0]      state_o,
  input logic [ID_W-1:0] id_o,
  input logic            id_valid_o,
  input logic            len_err_o
);

  assert_hold_no_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tck_rise |=> $stable(state_o));

  assert_reset_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_rise && tms_s && state_o == 4'd0) |=> state_o == 4'd0);

  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |=> !id_valid_o);

  assert_valid_in_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> state_o == 4'd8);

  assert_valid_err_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_valid_o && len_err_o));

  assert_err_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd3 && $past(state_o) != 4'd3) |-> !len_err_o);

  assert_id_only_on_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(id_o) |-> id_valid_o);

endmodule

bind jtag_idcode_monitor jtag_idcode_monitor_chk #(.ID_W(ID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tck_rise   (tck_rise),
  .tms_s      (tms_s),
  .state_o    (state_o),
  .id_o       (id_o),
  .id_valid_o (id_valid_o),
  .len_err_o  (len_err_o)
);

// File: tb/jtag_idcode_monitor_test.sv
module jtag_idcode_monitor_test;

  localparam int HALF = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tck = 1'b0, tms = 1'b1, tdo = 1'b1;
  logic [3:0]  state_o;
  logic [31:0] id_o;
  logic        id_valid_o, len_err_o;

  int n_chk = 0, n_err = 0, n_valid = 0, n_rise = 0;
  logic vld_prev = 1'b0;
  bit   done = 0;

  always #5 clk = ~clk;

  jtag_idcode_monitor uut (
    .clk_i (clk), .rst_ni (rst_n), .tck_i (tck), .tms_i (tms), .tdo_i (tdo),
    .state_o (state_o), .id_o (id_o), .id_valid_o (id_valid_o), .len_err_o (len_err_o)
  );

  always @(posedge clk) begin
    if (id_valid_o) n_valid++;
    if (id_valid_o && !vld_prev) n_rise++;
    vld_prev <= id_valid_o;
  end

  // recorded session, index = TCK edge number
  localparam logic [0:51] REF_TMS = 52'b1111101100000011_0100000000000000_0000000000000000_0001;
  localparam logic [0:51] REF_TDO = 52'b1111111111101111_1111110010010000_0010100001100000_0100;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic jbit(input logic m, input logic d);
    @(negedge clk);
    tms = m; tdo = d;
    repeat (HALF) @(negedge clk);
    tck = 1'b1;
    repeat (HALF) @(negedge clk);
    tck = 1'b0;
  endtask

  // from Run-Test/Idle: full DR scan of n bits, LSB first, then Update-DR
  task automatic dr_scan(input logic [63:0] bits, input int n);
    jbit(1, 0); jbit(0, 0); jbit(0, 0);
    for (int i = 0; i < n; i++) jbit(i == n - 1, bits[i]);
    jbit(1, 0);
  endtask

  task automatic t_reset;
    check("R1 state", 32'(state_o), 32'd0);
    check("R1 id", id_o, 32'd0);
    check("R1 valid", 32'(id_valid_o), 32'd0);
    check("R1 len_err", 32'(len_err_o), 32'd0);
  endtask

  task automatic t_reference;
    int v0 = n_valid;
    for (int i = 0; i < 52; i++) begin
      jbit(REF_TMS[i], REF_TDO[i]);
      if (i == 4)  check("R3 five ones to reset", 32'(state_o), 32'd0);
      if (i == 15) check("R2 update-ir", 32'(state_o), 32'd15);
      if (i == 19) check("R2 shift-dr", 32'(state_o), 32'd4);
    end
    check("R2 exit1-dr", 32'(state_o), 32'd5);
    check("R5 no valid before update", 32'(n_valid - v0), 32'd0);
    jbit(1, 0);
    check("R2 update-dr", 32'(state_o), 32'd8);
    check("R4 reference word", id_o, 32'h20614093);
    check("R5 one valid cycle", 32'(n_valid - v0), 32'd1);
    check("R5 one valid pulse", 32'(n_rise), 32'(n_valid));
    check("R6 no error on 32", 32'(len_err_o), 32'd0);
    jbit(0, 0);
    check("R2 idle", 32'(state_o), 32'd1);
  endtask

  task automatic t_short;
    int v0 = n_valid;
    dr_scan(64'h0000_0000_1234_5678, 31);
    jbit(0, 0);
    check("R6 short err", 32'(len_err_o), 32'd1);
    check("R6 short no valid", 32'(n_valid - v0), 32'd0);
    check("R6 short id kept", id_o, 32'h20614093);
  endtask

  task automatic t_long;
    int v0 = n_valid;
    jbit(1, 0); jbit(0, 0);
    check("R7 err cleared on capture", 32'(len_err_o), 32'd0);
    jbit(0, 0);
    for (int i = 0; i < 33; i++) jbit(i == 32, 1'b1);
    jbit(1, 0); jbit(0, 0);
    check("R6 long err", 32'(len_err_o), 32'd1);
    check("R6 long no valid", 32'(n_valid - v0), 32'd0);
    check("R6 long id kept", id_o, 32'h20614093);
  endtask

  task automatic t_pause;
    logic [31:0] w = 32'hA5C3_1E7F;
    int v0 = n_valid;
    jbit(1, 0); jbit(0, 0); jbit(0, 0);
    for (int i = 0; i < 10; i++) jbit(i == 9, w[i]);
    jbit(0, 1); jbit(0, 1);
    check("R8 pause-dr", 32'(state_o), 32'd6);
    jbit(1, 1); jbit(0, 1);
    check("R8 back to shift", 32'(state_o), 32'd4);
    for (int i = 10; i < 32; i++) jbit(i == 31, w[i]);
    jbit(1, 0); jbit(0, 0);
    check("R8 paused word", id_o, w);
    check("R8 paused valid", 32'(n_valid - v0), 32'd1);
    check("R7 no err", 32'(len_err_o), 32'd0);
  endtask

  task automatic t_ir_and_reset;
    int v0 = n_valid;
    jbit(1, 0); jbit(1, 0); jbit(0, 0); jbit(0, 0);
    for (int i = 0; i < 32; i++) jbit(i == 31, 1'b0);
    jbit(1, 0);
    check("R9 update-ir", 32'(state_o), 32'd15);
    jbit(0, 0);
    jbit(1, 0); jbit(0, 0); jbit(0, 0);
    for (int i = 0; i < 20; i++) jbit(0, 1'b0);
    for (int i = 0; i < 5; i++) jbit(1, 1'b0);
    check("R3 reset from shift", 32'(state_o), 32'd0);
    jbit(1, 0);
    check("R3 stays reset", 32'(state_o), 32'd0);
    check("R9 no valid", 32'(n_valid - v0), 32'd0);
    check("R9 id kept", id_o, 32'hA5C3_1E7F);
    jbit(0, 0);
  endtask

  task automatic t_no_edge;
    logic [3:0] s0 = state_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); tms = i[0]; tdo = i[1];
    end
    repeat (6) @(negedge clk);
    check("R2 no tck edge", 32'(state_o), 32'(s0));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reference();
    t_short();
    t_long();
    t_pause();
    t_ir_and_reset();
    t_no_edge();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule